// File: doc/BRIEF.md
# Configurable Parallel-Prefix Adder

This block adds two N-bit operands and a carry-in, producing an N-bit sum and a carry-out in one combinational pass. N must be a power of two. Each bit forms a generate and propagate pair. A logarithmic tree of group generate/propagate merge cells then turns those pairs into every prefix carry.

The carry-in is folded into bit 0 before the tree, so bit 0's group generate already includes it. Each sum bit is its bit propagate XORed with the prefix carry arriving from the bits below it.

A compile-time enumeration selects how the tree is wired. There are three choices:
- **Full:** every node combines with the node at distance 2^s on each of log2 N stages. Maximum fanout is 2, but many wires run in parallel.
- **Halving:** on each of log2 N stages, the upper half of every block takes the carry from the top of its lower half. This uses fewer cells but has high fanout.
- **Sparse:** an up-sweep followed by a down-sweep, 2·log2 N − 1 stages in all. It uses about 2N cells and has fanout 2.

An unsupported selector value, or an N that is not a power of two, stops elaboration.

Top module: `tree_adder`

## Requirements
- R1: With the full topology (selector value 0), {cout, sum} equals opa + opb + cin for every operand pair.
- R2: With the halving topology (selector value 1), {cout, sum} equals opa + opb + cin for every operand pair.
- R3: With the sparse topology (selector value 2), {cout, sum} equals opa + opb + cin for every operand pair.
- R4: When opb is the bitwise complement of opa, every bit propagates. The carry-in then reaches cout unchanged, and sum is all ones when cin is 0 and all zeros when cin is 1.
- R5: When both top operand bits are 1, cout is 1 whatever the lower bits. When both are 0, cout is 0 whatever the lower bits. More generally, the carry out of any bit where the two operand bits are equal is that bit's value.
- R6: With one operand zero, sum equals the other operand plus cin. An all-ones operand plus cin = 1 wraps to zero with cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand |
| opb | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
A wrong merge partner or a missing pass-through in any tree stage corrupts one prefix carry. That fault appears at once on the sum bit just above it, and on cout whenever the bad group reaches the top bit. There is no state, so every fault is visible in the same evaluation as the operands that expose it.

Exhaustive 8-bit operand sweeps reach every merge cell of the small trees with both carry polarities. The long propagate chains and the generate/kill boundaries are driven on purpose at 32 bits, where a late stage error would otherwise hide behind random data.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
package pfx_pkg;

  typedef enum logic [1:0] {
    TOPO_FULL    = 2'd0,
    TOPO_HALVING = 2'd1,
    TOPO_SPARSE  = 2'd2
  } topo_e;

  function automatic bit is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

  // number of merge stages for a given topology and log2 width
  function automatic int stage_count(input topo_e t, input int lg);
    if (t == TOPO_SPARSE) return 2 * lg - 1;
    return lg;
  endfunction

  // index of the lower group that node i merges with at stage s, -1 = pass
  function automatic int partner(input topo_e t, input int lg, input int s, input int i);
    int d;
    int k;
    case (t)
      TOPO_FULL: begin
        d = 1 << s;
        return (i >= d) ? i - d : -1;
      end
      TOPO_HALVING: begin
        d = 1 << s;
        if ((i & d) != 0) return ((i >> (s + 1)) << (s + 1)) + d - 1;
        return -1;
      end
      default: begin
        if (s < lg) begin
          d = 1 << s;
          if (((i + 1) % (2 * d)) == 0) return i - d;
          return -1;
        end
        k = 2 * lg - 2 - s;
        d = 1 << k;
        if ((((i + 1) % (2 * d)) == d) && (i >= 2 * d)) return i - d;
        return -1;
      end
    endcase
  endfunction

  // running AND from bit 0 upward: r[i] = &v[i:0]
  function automatic logic [63:0] prefix_and(input logic [63:0] v, input int n);
    logic [63:0] r;
    logic acc;
    r = '0;
    acc = 1'b1;
    for (int i = 0; i < n; i++) begin
      acc = acc & v[i];
      r[i] = acc;
    end
    return r;
  endfunction

endpackage

// File: rtl/pfx_bitpg.sv
`timescale 1ns/1ps
module pfx_bitpg #(
  parameter int N = 32
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         cin,
  output logic [N-1:0] bit_p,
  output logic [N-1:0] grp_g,
  output logic [N-1:0] grp_p
);
  // bit 0 absorbs the carry-in as the base case of the prefix
  assign bit_p = opa ^ opb;
  assign grp_p = {bit_p[N-1:1], 1'b0};
  assign grp_g = {opa[N-1:1] & opb[N-1:1], (opa[0] & opb[0]) | (bit_p[0] & cin)};
endmodule

// File: rtl/pfx_tree.sv
`timescale 1ns/1ps
module pfx_tree #(
  parameter int            N    = 32,
  parameter pfx_pkg::topo_e TOPO = pfx_pkg::TOPO_FULL
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:0] p_in,
  output logic [N-1:0] g_out
);
  localparam int LG  = $clog2(N);
  localparam int STG = pfx_pkg::stage_count(TOPO, LG);

  if (!pfx_pkg::is_pow2(N)) begin : g_bad_width
    $error("pfx_tree: width %0d is not a power of two", N);
  end
  if (int'(TOPO) > 2) begin : g_bad_topo
    $error("pfx_tree: topology code %0d unsupported", int'(TOPO));
  end

  logic [STG:0][N-1:0] g_st;
  logic [STG:0][N-1:0] p_st;

  assign g_st[0] = g_in;
  assign p_st[0] = p_in;

  for (genvar s = 0; s < STG; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_node
      localparam int J = pfx_pkg::partner(TOPO, LG, s, i);
      if (J >= 0) begin : g_merge
        assign g_st[s+1][i] = g_st[s][i] | (p_st[s][i] & g_st[s][J]);
        assign p_st[s+1][i] = p_st[s][i] & p_st[s][J];
      end else begin : g_pass
        assign g_st[s+1][i] = g_st[s][i];
        assign p_st[s+1][i] = p_st[s][i];
      end
    end
  end

  assign g_out = g_st[STG];

  // every final group propagate must span down to bit 0
  always_comb begin
    if (!$isunknown(p_in)) begin
      AST_PREFIX_SPAN: assert (p_st[STG] == N'(pfx_pkg::prefix_and(64'(p_in), N))); // R4
    end
  end
endmodule

// File: rtl/pfx_sumxor.sv
`timescale 1ns/1ps
module pfx_sumxor #(
  parameter int N = 32
) (
  input  logic [N-1:0] bit_p,
  input  logic [N-1:0] pre_g,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic [N-1:0] sum,
  output logic         cout
);
  assign carry = {pre_g, cin};
  assign sum   = bit_p ^ carry[N-1:0];
  assign cout  = carry[N];
endmodule

// File: rtl/tree_adder.sv
`timescale 1ns/1ps
module tree_adder #(
  parameter int             N    = 32,
  parameter pfx_pkg::topo_e TOPO = pfx_pkg::TOPO_FULL
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N-1:0] bit_p;
  logic [N-1:0] grp_g;
  logic [N-1:0] grp_p;
  logic [N-1:0] pre_g;
  logic [N:0]   carry;

  pfx_bitpg #(.N(N)) u_bitpg (
    .opa(opa), .opb(opb), .cin(cin),
    .bit_p(bit_p), .grp_g(grp_g), .grp_p(grp_p)
  );

  pfx_tree #(.N(N), .TOPO(TOPO)) u_tree (
    .g_in(grp_g), .p_in(grp_p), .g_out(pre_g)
  );

  pfx_sumxor #(.N(N)) u_sum (
    .bit_p(bit_p), .pre_g(pre_g), .cin(cin),
    .carry(carry), .sum(sum), .cout(cout)
  );

  always_comb begin
    if (!$isunknown({opa, opb, cin})) begin
      AST_SUM_EXACT: assert ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + (N+1)'(cin))); // R1 R2 R3
      if ((opa ^ opb) == '1) begin
        AST_CHAIN_PASS: assert (cout == cin); // R4
      end
      for (int i = 0; i < N; i++) begin
        if (opa[i] == opb[i]) begin
          AST_GEN_KILL: assert (carry[i+1] == opa[i]); // R5
        end
      end
      if (opb == '0) begin
        AST_ZERO_OPERAND: assert (sum == opa + N'(cin)); // R6
      end
    end
  end
endmodule

// File: tb/tree_adder_tb.sv
`timescale 1ns/1ps
module tree_adder_tb;
  import pfx_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  a8, b8;
  logic [31:0] a32, b32;
  logic        ci;
  logic [7:0]  s8  [3];
  logic        c8  [3];
  logic [31:0] s32 [3];
  logic        c32 [3];

  int n_chk = 0;
  int n_err = 0;
  string tg [3] = '{"R1", "R2", "R3"};

  logic [8:0]  q8  [$];
  logic [32:0] q32 [$];

  for (genvar t = 0; t < 3; t++) begin : g_w8
    tree_adder #(.N(8), .TOPO(topo_e'(t))) u_dut (
      .opa(a8), .opb(b8), .cin(ci), .sum(s8[t]), .cout(c8[t])
    );
  end
  for (genvar t = 0; t < 3; t++) begin : g_w32
    tree_adder #(.N(32), .TOPO(topo_e'(t))) u_dut (
      .opa(a32), .opb(b32), .cin(ci), .sum(s32[t]), .cout(c32[t])
    );
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // drive one vector at the rising edge, compare against the model at the falling edge
  task automatic apply(input logic [7:0] x8, input logic [7:0] y8,
                       input logic [31:0] x32, input logic [31:0] y32,
                       input logic c, input string req);
    logic [8:0]  e8;
    logic [32:0] e32;
    @(posedge clk);
    a8 = x8; b8 = y8; a32 = x32; b32 = y32; ci = c;
    q8.push_back(9'(int'(x8) + int'(y8) + int'(c)));
    q32.push_back(33'(longint'(x32) + longint'(y32) + longint'(c)));
    @(negedge clk);
    e8  = q8.pop_front();
    e32 = q32.pop_front();
    for (int t = 0; t < 3; t++) begin
      n_chk++;
      if ({c8[t], s8[t]} !== e8) begin
        n_err++;
        $display("FAIL %s/%s w8 a=%h b=%h c=%0d: got %h exp %h",
                 req, tg[t], x8, y8, c, {c8[t], s8[t]}, e8);
      end
      n_chk++;
      if ({c32[t], s32[t]} !== e32) begin
        n_err++;
        $display("FAIL %s/%s w32 a=%h b=%h c=%0d: got %h exp %h",
                 req, tg[t], x32, y32, c, {c32[t], s32[t]}, e32);
      end
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    a8 = '0; b8 = '0; a32 = '0; b32 = '0; ci = 1'b0;
    // reset phase: zero operands give zero result (R6)
    repeat (3) apply(8'h00, 8'h00, 32'h0, 32'h0, 1'b0, "R6");
    rst_n = 1'b1;

    // exhaustive 8-bit sweep per topology, random 32-bit alongside (R1 R2 R3)
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          apply(8'(x), 8'(y), $urandom, $urandom, 1'(c), "sweep");
        end
      end
    end

    // full propagate chains (R4)
    apply(8'h5A, 8'hA5, 32'h1234_5678, ~32'h1234_5678, 1'b0, "R4");
    apply(8'h5A, 8'hA5, 32'h1234_5678, ~32'h1234_5678, 1'b1, "R4");
    apply(8'hFF, 8'h00, 32'hFFFF_FFFF, 32'h0, 1'b0, "R4");
    for (int k = 0; k < 8; k++) begin
      r = $urandom;
      apply(r[7:0], ~r[7:0], r, ~r, 1'(k), "R4");
    end

    // top-bit generate and kill with random lower bits (R5)
    for (int k = 0; k < 8; k++) begin
      apply(8'h80 | 8'($urandom), 8'h80 | 8'($urandom),
            32'h8000_0000 | $urandom, 32'h8000_0000 | $urandom, 1'(k), "R5");
      apply(8'h7F & 8'($urandom), 8'h7F & 8'($urandom),
            32'h7FFF_FFFF & $urandom, 32'h7FFF_FFFF & $urandom, 1'(k), "R5");
    end

    // zero operand and wrap-around (R6)
    apply(8'hFF, 8'h00, 32'hFFFF_FFFF, 32'h0, 1'b1, "R6");
    apply(8'h00, 8'h00, 32'h0, 32'h0, 1'b1, "R6");
    for (int k = 0; k < 8; k++) begin
      apply(8'($urandom), 8'h00, $urandom, 32'h0, 1'(k), "R6");
    end

    // random wide vectors per topology (R1 R2 R3)
    for (int k = 0; k < 4000; k++) begin
      apply(8'($urandom), 8'($urandom), $urandom, $urandom, 1'($urandom), "rand");
    end

    finish_run();
  end
endmodule